// File: doc/BRIEF.md
# Stalling Entropy Register

This block is a 256-bit read-only register that hands fresh random words to a processor datapath. An instruction that wants the value raises read intent. If a word is already cached, the block reports ready in the same cycle and presents the word. If no word is cached, the block sends one request pulse to an external entropy source and keeps ready low until a word has arrived and been committed. A separate prefetch strobe can start the same request early, so that the word is already waiting when the read comes.

Every change of architectural state takes effect only at a commit strobe from the pipeline. This applies to loading an arrived word into the cache and to using up a word that was read. A word that has been read is therefore invalidated at the next commit, and each word is delivered at most once. A pending flag allows only one outstanding request. This holds through the window between a word's arrival and its commit. Two health-error flags travel with each word. They appear on the escalation outputs only when that word is read.

Read back-pressure works as a request/ready pair. The datapath holds read intent and may treat the word as taken only in a cycle where ready is high. The entropy return is valid-only: the block accepts it whenever a request is pending and nothing is staged, and ignores it otherwise. A start strobe drops all in-flight state but keeps a committed cached word.

Top module: `entropy_reg`

## Requirements
- R1: `rd_data_o` carries the whole 256-bit cached word. `rd_narrow_o` carries bits 31:0 of that same word.
- R2: Asserting `wr_en_i`, with any `wr_data_i`, changes neither the cached word nor any output.
- R3: When `rd_req_i` is high and a committed word is cached, `rd_ready_o` is high in that same cycle and `rd_data_o` equals the word. Otherwise `rd_ready_o` is low.
- R4: When `rd_req_i` is high, no word is cached and no request is pending, `ent_req_o` is high for exactly one cycle, starting the cycle after. While the request is pending, no further pulse is issued.
- R5: `prefetch_i` issues a request under the same conditions as R4. It issues none while a word is cached or a request is pending.
- R6: An `ent_valid_i` that arrives while a request is pending is held back until the next `commit_i`. After that commit edge the word is readable and the pending flag is clear. No request is issued between the arrival and the commit.
- R7: A commit at or after a ready read invalidates the cached word. A later read then stalls and issues a fresh request.
- R8: The cycle after a ready read, `esc_fips_o` and `esc_rep_o` equal the two health flags that arrived with that word. Both clear at the commit that loads a new word.
- R9: `start_i` takes priority over everything else. It clears the pending flag and both escalation outputs, drops a staged but uncommitted word, and cancels an uncommitted consumption. It keeps a committed cached word.
- R10: After reset no word is cached, nothing is pending, and `ent_req_o`, `esc_fips_o` and `esc_rep_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read intent from the executing instruction |
| wr_en_i | input | 1 | Instruction write strobe (no effect) |
| wr_data_i | input | 256 | Instruction write data (no effect) |
| prefetch_i | input | 1 | Request a word ahead of a read |
| commit_i | input | 1 | Commit pending state changes |
| start_i | input | 1 | Start of a new operation |
| ent_valid_i | input | 1 | Entropy word returned |
| ent_data_i | input | 256 | Returned entropy word |
| ent_fips_err_i | input | 1 | FIPS health error for the returned word |
| ent_rep_err_i | input | 1 | Repetition health error for the returned word |
| rd_ready_o | output | 1 | Read can complete this cycle |
| rd_data_o | output | 256 | Cached word |
| rd_narrow_o | output | 32 | Low 32 bits of the cached word |
| ent_req_o | output | 1 | One-cycle request to the entropy source |
| esc_fips_o | output | 1 | Escalated FIPS health error |
| esc_rep_o | output | 1 | Escalated repetition health error |

## Verification
`rd_ready_o`, `rd_data_o` and `rd_narrow_o` are combinational from the current read intent and the cached state, so they are due in the cycle the intent is driven. The bench samples them half a cycle after driving, before the edge. `ent_req_o` and the escalation flags are registered, so they are due one edge after the cycle that caused them. The bench compares them at the following falling edge. A committed word is readable only from the cycle after the commit edge, so the bench checks readiness after a commit in the next cycle. A bench-side model, advanced once per edge, supplies every expected value at exactly these points.

// File: rtl/entropy_reg_pkg.sv
package entropy_reg_pkg;
  parameter int unsigned ENT_W    = 256;
  parameter int unsigned NARROW_W = 32;

  typedef struct packed {
    logic fips;
    logic rep;
  } health_t;
endpackage

// File: rtl/entropy_req_gate.sv
// Pending flag and single request pulse; one outstanding request at most.
module entropy_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rd_req_i,
  input  logic prefetch_i,
  input  logic cache_valid_i,
  input  logic load_commit_i,
  output logic pend_o,
  output logic req_o
);
  logic issue;

  assign issue = !start_i && !cache_valid_i && !pend_o && (rd_req_i || prefetch_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      req_o <= issue;
      if (start_i)            pend_o <= 1'b0;
      else if (issue)         pend_o <= 1'b1;
      else if (load_commit_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/entropy_stage.sv
// Holds an arrived word until the next commit.
module entropy_stage
  import entropy_reg_pkg::*;
#(
  parameter int unsigned W = ENT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         commit_i,
  input  logic         pend_i,
  input  logic         ent_valid_i,
  input  logic [W-1:0] ent_data_i,
  input  health_t      ent_health_i,
  output logic [W-1:0] stage_data_o,
  output health_t      stage_health_o,
  output logic         load_commit_o
);
  logic stage_valid_q;
  logic accept;

  assign accept        = ent_valid_i && pend_i && !stage_valid_q && !start_i;
  assign load_commit_o = commit_i && stage_valid_q && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid_q  <= 1'b0;
      stage_data_o   <= '0;
      stage_health_o <= '0;
    end else if (start_i || load_commit_o) begin
      stage_valid_q <= 1'b0;
    end else if (accept) begin
      stage_valid_q  <= 1'b1;
      stage_data_o   <= ent_data_i;
      stage_health_o <= ent_health_i;
    end
  end
endmodule

// File: rtl/entropy_cache.sv
// Committed word, consume-on-commit tracking and escalation flags.
module entropy_cache
  import entropy_reg_pkg::*;
#(
  parameter int unsigned W = ENT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         commit_i,
  input  logic         rd_req_i,
  input  logic         load_commit_i,
  input  logic [W-1:0] stage_data_i,
  input  health_t      stage_health_i,
  output logic         cache_valid_o,
  output logic [W-1:0] cache_data_o,
  output logic         rd_ready_o,
  output health_t      esc_o
);
  logic    consume_q;
  health_t cache_health_q;

  assign rd_ready_o = rd_req_i && cache_valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      consume_q      <= 1'b0;
      cache_valid_o  <= 1'b0;
      cache_data_o   <= '0;
      cache_health_q <= '0;
      esc_o          <= '0;
    end else begin
      if (start_i || commit_i) consume_q <= 1'b0;
      else if (rd_ready_o)     consume_q <= 1'b1;

      if (load_commit_i) begin
        cache_valid_o  <= 1'b1;
        cache_data_o   <= stage_data_i;
        cache_health_q <= stage_health_i;
      end else if (commit_i && !start_i && (consume_q || rd_ready_o)) begin
        cache_valid_o <= 1'b0;
      end

      if (start_i || load_commit_i) esc_o <= '0;
      else if (rd_ready_o)          esc_o <= cache_health_q;
    end
  end
endmodule

// File: rtl/entropy_reg.sv
module entropy_reg
  import entropy_reg_pkg::*;
#(
  parameter int unsigned DATA_W = ENT_W,
  parameter int unsigned RD_NW  = NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              prefetch_i,
  input  logic              commit_i,
  input  logic              start_i,
  input  logic              ent_valid_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic              ent_fips_err_i,
  input  logic              ent_rep_err_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [RD_NW-1:0]  rd_narrow_o,
  output logic              ent_req_o,
  output logic              esc_fips_o,
  output logic              esc_rep_o
);
  logic              pend_q;
  logic              cache_valid;
  logic              load_commit;
  logic [DATA_W-1:0] stage_data;
  logic [DATA_W-1:0] cache_data;
  health_t           stage_health;
  health_t           esc;
  health_t           in_health;
  logic              wr_unused_sink;

  // Instruction writes are architecturally dropped.
  assign wr_unused_sink = wr_en_i ^ (^wr_data_i);

  assign in_health = '{fips: ent_fips_err_i, rep: ent_rep_err_i};

  entropy_req_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rd_req_i      (rd_req_i),
    .prefetch_i    (prefetch_i),
    .cache_valid_i (cache_valid),
    .load_commit_i (load_commit),
    .pend_o        (pend_q),
    .req_o         (ent_req_o)
  );

  entropy_stage #(.W(DATA_W)) u_stage (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .commit_i       (commit_i),
    .pend_i         (pend_q),
    .ent_valid_i    (ent_valid_i),
    .ent_data_i     (ent_data_i),
    .ent_health_i   (in_health),
    .stage_data_o   (stage_data),
    .stage_health_o (stage_health),
    .load_commit_o  (load_commit)
  );

  entropy_cache #(.W(DATA_W)) u_cache (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .commit_i       (commit_i),
    .rd_req_i       (rd_req_i),
    .load_commit_i  (load_commit),
    .stage_data_i   (stage_data),
    .stage_health_i (stage_health),
    .cache_valid_o  (cache_valid),
    .cache_data_o   (cache_data),
    .rd_ready_o     (rd_ready_o),
    .esc_o          (esc)
  );

  assign rd_data_o   = cache_data;
  assign rd_narrow_o = cache_data[RD_NW-1:0];
  assign esc_fips_o  = esc.fips;
  assign esc_rep_o   = esc.rep;
endmodule

// File: rtl/entropy_reg_checker.sv
module entropy_reg_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rd_ready_o,
  input logic ent_req_o,
  input logic esc_fips_o,
  input logic esc_rep_o,
  input logic pend_q,
  input logic cache_valid
);
  p_req_is_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_req_o |=> !ent_req_o);

  p_no_req_while_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !ent_req_o);

  p_req_marks_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_req_o |-> pend_q);

  p_no_req_when_cached_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |=> !ent_req_o);

  p_esc_only_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esc_fips_o) |-> $past(rd_ready_o));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!pend_q && !esc_fips_o && !esc_rep_o));

  p_start_keeps_cache_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cache_valid) |=> cache_valid);
endmodule

bind entropy_reg entropy_reg_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rd_ready_o  (rd_ready_o),
  .ent_req_o   (ent_req_o),
  .esc_fips_o  (esc_fips_o),
  .esc_rep_o   (esc_rep_o),
  .pend_q      (pend_q),
  .cache_valid (cache_valid)
);

// File: tb/tb_entropy_reg.sv
`timescale 1ns/100ps
module tb_entropy_reg;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_req = 1'b0, wr_en = 1'b0, prefetch = 1'b0, commit = 1'b0, start = 1'b0;
  logic         ent_valid = 1'b0, fips = 1'b0, rep = 1'b0;
  logic [255:0] wr_data = '0, ent_data = '0;
  logic         rd_ready, ent_req, esc_fips, esc_rep;
  logic [255:0] rd_data;
  logic [31:0]  rd_narrow;

  int n_checks = 0;
  int n_errors = 0;

  // bench-side expected state
  bit           m_v, m_p, m_s, m_c, m_req;
  logic [255:0] m_d, m_sd;
  bit [1:0]     m_h, m_sh, m_esc;

  always #2 clk = ~clk;

  entropy_reg dut (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .prefetch_i(prefetch), .commit_i(commit), .start_i(start), .ent_valid_i(ent_valid),
    .ent_data_i(ent_data), .ent_fips_err_i(fips), .ent_rep_err_i(rep),
    .rd_ready_o(rd_ready), .rd_data_o(rd_data), .rd_narrow_o(rd_narrow),
    .ent_req_o(ent_req), .esc_fips_o(esc_fips), .esc_rep_o(esc_rep)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic model_edge();
    bit rdy, gate, acc, cons;
    rdy  = rd_req && m_v;
    gate = !start && !m_v && !m_p && (rd_req || prefetch);
    acc  = ent_valid && m_p && !m_s;
    cons = m_c || rdy;
    if (start) begin
      m_p = 0; m_s = 0; m_c = 0; m_esc = 0; m_req = 0;
    end else begin
      m_req = gate;
      if (rdy) m_esc = m_h;
      if (commit && m_s) begin
        m_v = 1; m_d = m_sd; m_h = m_sh; m_p = 0; m_s = 0; m_esc = 0;
      end else if (commit && cons) begin
        m_v = 0;
      end
      if (gate) m_p = 1;
      if (acc) begin m_s = 1; m_sd = ent_data; m_sh = {fips, rep}; end
      m_c = commit ? 1'b0 : cons;
    end
  endtask

  task automatic settle();
    #0.5;
  endtask

  // Called just after a falling edge with inputs driven.
  task automatic cycle();
    bit exp_rdy;
    settle();
    exp_rdy = rd_req && m_v;
    chk(rd_ready === exp_rdy, "R3 ready", 256'(rd_ready), 256'(exp_rdy));
    if (exp_rdy) begin
      chk(rd_data === m_d, "R3 data", rd_data, m_d);
      chk(rd_narrow === m_d[31:0], "R1 narrow", 256'(rd_narrow), 256'(m_d[31:0]));
    end
    model_edge();
    @(negedge clk);
    chk(ent_req === m_req, "R4 request", 256'(ent_req), 256'(m_req));
    chk({esc_fips, esc_rep} === m_esc, "R8 escalation", 256'({esc_fips, esc_rep}), 256'(m_esc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [255:0] a, b, c, d;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_v = 0; m_p = 0; m_s = 0; m_c = 0; m_req = 0; m_d = '0; m_sd = '0;
    m_h = 0; m_sh = 0; m_esc = 0;
    repeat (3) @(negedge clk);
    chk(ent_req === 1'b0, "R10 req", 256'(ent_req), 0);
    chk({esc_fips, esc_rep} === 2'b00, "R10 esc", 256'({esc_fips, esc_rep}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_req = 1; settle();
    chk(rd_ready === 1'b0, "R10 empty", 256'(rd_ready), 0);

    // R4: stall and one request
    cycle();
    chk(ent_req === 1'b1, "R4 first pulse", 256'(ent_req), 1);
    cycle();
    chk(ent_req === 1'b0, "R4 no repeat", 256'(ent_req), 0);

    // R6: arrival held until commit
    a = rnd256();
    ent_valid = 1; ent_data = a; fips = 1; rep = 0;
    cycle();
    ent_valid = 0; settle();
    chk(rd_ready === 1'b0, "R6 not before commit", 256'(rd_ready), 0);
    cycle();
    chk(ent_req === 1'b0, "R6 no request before commit", 256'(ent_req), 0);
    commit = 1; cycle(); commit = 0;

    // R2: write ignored
    rd_req = 0; wr_en = 1; wr_data = ~a; cycle(); wr_en = 0;
    rd_req = 1; settle();
    chk(rd_ready === 1'b1, "R6 readable after commit", 256'(rd_ready), 1);
    chk(rd_data === a, "R2 write ignored", rd_data, a);
    chk(rd_narrow === a[31:0], "R1 low bits", 256'(rd_narrow), 256'(a[31:0]));
    cycle();
    chk({esc_fips, esc_rep} === 2'b10, "R8 flags on read", 256'({esc_fips, esc_rep}), 2);

    // R7: consumed at commit
    rd_req = 0; commit = 1; cycle(); commit = 0;
    rd_req = 1; settle();
    chk(rd_ready === 1'b0, "R7 invalid after commit", 256'(rd_ready), 0);
    cycle();
    chk(ent_req === 1'b1, "R7 fresh request", 256'(ent_req), 1);
    rd_req = 0;
    b = rnd256();
    ent_valid = 1; ent_data = b; fips = 0; rep = 0; cycle(); ent_valid = 0;
    commit = 1; cycle(); commit = 0;
    chk({esc_fips, esc_rep} === 2'b00, "R8 cleared on load", 256'({esc_fips, esc_rep}), 0);

    // R5: prefetch blocked while cached
    prefetch = 1; cycle(); prefetch = 0;
    chk(ent_req === 1'b0, "R5 cached blocks prefetch", 256'(ent_req), 0);

    // R9: start keeps cache, cancels consumption
    start = 1; cycle(); start = 0;
    rd_req = 1; settle();
    chk(rd_ready === 1'b1 && rd_data === b, "R9 cache kept", rd_data, b);
    cycle(); rd_req = 0;
    start = 1; cycle(); start = 0;
    commit = 1; cycle(); commit = 0;
    rd_req = 1; settle();
    chk(rd_ready === 1'b1, "R9 consumption cancelled", 256'(rd_ready), 1);
    commit = 1; cycle(); commit = 0; rd_req = 0;

    // R5: prefetch issues request when empty
    prefetch = 1; cycle(); prefetch = 0;
    chk(ent_req === 1'b1, "R5 prefetch request", 256'(ent_req), 1);
    cycle();

    // R9: start drops staged word and pending flag
    c = rnd256();
    ent_valid = 1; ent_data = c; cycle(); ent_valid = 0;
    start = 1; cycle(); start = 0;
    commit = 1; cycle(); commit = 0;
    rd_req = 1; settle();
    chk(rd_ready === 1'b0, "R9 staged dropped", 256'(rd_ready), 0);
    cycle();
    chk(ent_req === 1'b1, "R9 pending cleared", 256'(ent_req), 1);
    d = rnd256();
    ent_valid = 1; ent_data = d; fips = 0; rep = 1; cycle(); ent_valid = 0;
    commit = 1; cycle(); commit = 0;
    cycle();
    chk({esc_fips, esc_rep} === 2'b01, "R8 repetition flag", 256'({esc_fips, esc_rep}), 1);
    rd_req = 0; commit = 1; cycle(); commit = 0;

    // constrained random phase against the model
    for (int n = 0; n < 3000; n++) begin
      rd_req   = ($urandom % 10) < 4;
      prefetch = ($urandom % 20) == 0;
      wr_en    = ($urandom % 10) == 0;
      wr_data  = rnd256();
      commit   = ($urandom % 10) < 3;
      start    = ($urandom % 50) == 0;
      ent_valid = m_p && !m_s && (($urandom % 4) == 0);
      ent_data = rnd256();
      fips     = $urandom % 2;
      rep      = $urandom % 2;
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule